// File: doc/BRIEF.md
# Serial Ferroelectric Memory Target Emulator

This block is a synthesizable SPI target that answers like a small serial ferroelectric memory. An SPI controller under test drives clock, chip select and MOSI into it and reads MISO back, with no behavioural model needed outside the chip. Every chip-select-low period is one frame: the first byte is a command, and the bytes after it are taken or returned according to that command. The target keeps a write-enable latch, exposes it through a status byte, holds a byte array indexed by a 20-bit address, and can be put into a low-power hibernate state.

All SPI pins are brought into the system clock domain through a synchronizer and sampled there. A controller state machine walks through the states IDLE, OPCODE, ADDR_HI, ADDR_MID, ADDR_LO, WR_DATA, RD_DATA, STATUS, SKIP, SLEEP and WAKE. Chip select falling moves IDLE to OPCODE. The opcode byte moves OPCODE to STATUS (0x05), to ADDR_HI (0x03, or 0x02 with the latch set), to SLEEP (0xB9), and to SKIP for everything else. The three address bytes step ADDR_HI to ADDR_MID to ADDR_LO, and then to WR_DATA or RD_DATA. A finished data or status byte leads to SKIP. Chip select rising returns every state except SLEEP to IDLE. A chip-select fall moves SLEEP to WAKE, and the rise that ends that frame moves WAKE to IDLE.

The array depth is a parameter and must be a power of two no larger than 2^20. The address is reduced modulo the depth.

Top module: `serial_mem_target`

## Requirements
- R1: The serial bus is SPI mode 0: SCLK idles low, MOSI is sampled on the rising edge, MISO changes after the falling edge, bytes travel most significant bit first, and MISO is low during the opcode byte. After reset MISO is low and the hibernate output is low.
- R2: Opcode 0x06 sets the write-enable latch and opcode 0x04 clears it, each in a one-byte frame.
- R3: After opcode 0x05, the status byte is shifted out on MISO in the next byte slot. Bit 1 holds the write-enable latch and all other bits read 0.
- R4: Opcode 0x02 is followed by three address bytes, most significant first, and one data byte, which is stored at that address. The address is bits 3:0 of the first address byte followed by the next two bytes; bits 7:4 of the first byte are ignored.
- R5: Opcode 0x03 is followed by three address bytes in the R4 layout, and the addressed byte is shifted out on MISO in the slot that follows.
- R6: The stored or read location is the 20-bit address modulo DEPTH, so addresses that differ only above the index bits reach the same byte.
- R7: A 0x02 frame received while the latch is clear changes no memory.
- R8: The latch clears when chip select rises at the end of a 0x02 frame whose data byte has been stored.
- R9: Chip select rising at any point abandons the command in progress: a partially sent data byte is not stored, a write that did not complete leaves the latch set, and the next frame decodes its first byte as an opcode.
- R10: Any other opcode, for example 0x0B, 0x42, 0x9F, 0xC2 or 0xBA, with any following bytes, changes neither memory nor the latch.
- R11: Opcode 0xB9 raises the hibernate output and keeps it high across chip select rising. The next falling edge of chip select clears it. The frame that begins with that edge is discarded whole, and MISO stays low while hibernating.
- R12: MISO is low whenever chip select is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least eight times the SCLK rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | SPI serial clock from the controller |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data from the controller |
| spi_miso | output | 1 | Serial data to the controller, low when not selected |
| hibernating | output | 1 | High while the target is in hibernate |

## Verification
The bench builds the target with DEPTH = 16 and two synchronizer stages, and it runs SCLK at one sixteenth of the system clock. The small depth puts aliasing within reach: addresses 0x00015 and 0x12347 land on the same cells as 0x00005 and 0x00007, so R6 is checked with only a few frames. The slow SCLK leaves the synchronizer and byte pipeline enough margin that MISO settles before every rising edge, and it lets chip select be raised in the middle of a byte.

// File: rtl/smt_pkg.sv
package smt_pkg;

    localparam int BYTE_W     = 8;
    localparam int CNT_W      = $clog2(BYTE_W);
    localparam int ADDR_TOP_W = 4;
    localparam int ADDR_W     = ADDR_TOP_W + 2 * BYTE_W;
    localparam int WEL_BIT    = 1;

    localparam logic [BYTE_W-1:0] OP_SET_WEL   = 8'h06;
    localparam logic [BYTE_W-1:0] OP_CLR_WEL   = 8'h04;
    localparam logic [BYTE_W-1:0] OP_RD_STATUS = 8'h05;
    localparam logic [BYTE_W-1:0] OP_WRITE     = 8'h02;
    localparam logic [BYTE_W-1:0] OP_READ      = 8'h03;
    localparam logic [BYTE_W-1:0] OP_SLEEP     = 8'hB9;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_OPCODE,
        ST_ADDR_HI,
        ST_ADDR_MID,
        ST_ADDR_LO,
        ST_WR_DATA,
        ST_RD_DATA,
        ST_STATUS,
        ST_SKIP,
        ST_SLEEP,
        ST_WAKE
    } ctrl_state_t;

endpackage

// File: rtl/smt_sync.sv
module smt_sync #(
    parameter int               WIDTH     = 1,
    parameter int               STAGES    = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] pipe [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= RESET_VAL;
        end else begin
            pipe[0] <= d;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign q = pipe[STAGES-1];

endmodule

// File: rtl/smt_shifter.sv
module smt_shifter
    import smt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_s,
    input  logic              cs_n_s,
    input  logic              mosi_s,
    input  logic [BYTE_W-1:0] tx_data,
    output logic              frame_start,
    output logic              frame_end,
    output logic              cs_active,
    output logic              byte_valid,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              miso_bit
);

    logic              sclk_q;
    logic              cs_n_q;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-2:0] rx_sr;
    logic [BYTE_W-1:0] tx_sr;
    logic              sclk_rise;
    logic              sclk_fall;

    assign sclk_rise   = sclk_s & ~sclk_q;
    assign sclk_fall   = ~sclk_s & sclk_q;
    assign frame_start = cs_n_q & ~cs_n_s;
    assign frame_end   = ~cs_n_q & cs_n_s;
    assign cs_active   = ~cs_n_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q     <= 1'b0;
            cs_n_q     <= 1'b1;
            bit_cnt    <= '0;
            rx_sr      <= '0;
            tx_sr      <= '0;
            byte_valid <= 1'b0;
            rx_byte    <= '0;
        end else begin
            sclk_q     <= sclk_s;
            cs_n_q     <= cs_n_s;
            byte_valid <= 1'b0;
            if (cs_n_s) begin
                bit_cnt <= '0;
                tx_sr   <= '0;
            end else if (sclk_rise) begin
                rx_sr   <= {rx_sr[BYTE_W-3:0], mosi_s};
                bit_cnt <= bit_cnt + 1'b1;
                if (bit_cnt == CNT_W'(BYTE_W - 1)) begin
                    byte_valid <= 1'b1;
                    rx_byte    <= {rx_sr, mosi_s};
                end
            end else if (sclk_fall) begin
                if (bit_cnt == '0) tx_sr <= tx_data;
                else               tx_sr <= {tx_sr[BYTE_W-2:0], 1'b0};
            end
        end
    end

    assign miso_bit = tx_sr[BYTE_W-1] & cs_active;

endmodule

// File: rtl/smt_store.sv
module smt_store
    import smt_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata
);

    logic [BYTE_W-1:0] cells [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
        end else if (we) begin
            cells[idx] <= wdata;
        end
    end

    assign rdata = cells[idx];

endmodule

// File: rtl/smt_ctrl.sv
module smt_ctrl
    import smt_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              frame_end,
    input  logic              byte_valid,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic [BYTE_W-1:0] rd_data,
    output logic [BYTE_W-1:0] tx_data,
    output logic              mem_we,
    output logic [IDX_W-1:0]  mem_idx,
    output logic [BYTE_W-1:0] mem_wdata,
    output logic              wel,
    output logic              stored,
    output logic              sleeping
);

    ctrl_state_t       state;
    ctrl_state_t       state_nx;
    logic              wel_q;
    logic              stored_q;
    logic              is_write_q;
    logic [IDX_W-1:0]  idx_q;
    logic [BYTE_W-1:0] status;

    always_comb begin
        state_nx = state;
        if (state == ST_SLEEP) begin
            if (frame_start) state_nx = ST_WAKE;
        end else if (frame_end) begin
            state_nx = ST_IDLE;
        end else if (state == ST_IDLE) begin
            if (frame_start) state_nx = ST_OPCODE;
        end else if (byte_valid) begin
            unique case (state)
                ST_OPCODE: begin
                    if (rx_byte == OP_RD_STATUS)           state_nx = ST_STATUS;
                    else if (rx_byte == OP_READ)           state_nx = ST_ADDR_HI;
                    else if (rx_byte == OP_WRITE && wel_q) state_nx = ST_ADDR_HI;
                    else if (rx_byte == OP_SLEEP)          state_nx = ST_SLEEP;
                    else                                   state_nx = ST_SKIP;
                end
                ST_ADDR_HI:  state_nx = ST_ADDR_MID;
                ST_ADDR_MID: state_nx = ST_ADDR_LO;
                ST_ADDR_LO:  state_nx = is_write_q ? ST_WR_DATA : ST_RD_DATA;
                ST_WAKE:     state_nx = ST_WAKE;
                default:     state_nx = ST_SKIP;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wel_q      <= 1'b0;
            stored_q   <= 1'b0;
            is_write_q <= 1'b0;
            idx_q      <= '0;
        end else begin
            if (frame_end) begin
                stored_q <= 1'b0;
                if (stored_q) wel_q <= 1'b0;
            end
            if (byte_valid) begin
                unique case (state)
                    ST_OPCODE: begin
                        is_write_q <= (rx_byte == OP_WRITE);
                        if (rx_byte == OP_SET_WEL)      wel_q <= 1'b1;
                        else if (rx_byte == OP_CLR_WEL) wel_q <= 1'b0;
                    end
                    ST_ADDR_HI:              idx_q <= IDX_W'(rx_byte[ADDR_TOP_W-1:0]);
                    ST_ADDR_MID, ST_ADDR_LO: idx_q <= IDX_W'({idx_q, rx_byte});
                    ST_WR_DATA:              stored_q <= 1'b1;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        status          = '0;
        status[WEL_BIT] = wel_q;
        mem_we          = byte_valid && (state == ST_WR_DATA);
        mem_wdata       = rx_byte;
        mem_idx         = idx_q;
        wel             = wel_q;
        stored          = stored_q;
        sleeping        = (state == ST_SLEEP);
        unique case (state)
            ST_STATUS:  tx_data = status;
            ST_RD_DATA: tx_data = rd_data;
            default:    tx_data = '0;
        endcase
    end

endmodule

// File: rtl/serial_mem_target.sv
module serial_mem_target
    import smt_pkg::*;
#(
    parameter int DEPTH       = 256,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic spi_sclk,
    input  logic spi_cs_n,
    input  logic spi_mosi,
    output logic spi_miso,
    output logic hibernating
);

    localparam int IDX_W = $clog2(DEPTH);

    logic [2:0]        pins_s;
    logic              frame_start;
    logic              frame_end;
    logic              cs_active;
    logic              byte_valid;
    logic [BYTE_W-1:0] rx_byte;
    logic [BYTE_W-1:0] tx_data;
    logic [BYTE_W-1:0] rd_data;
    logic [BYTE_W-1:0] mem_wdata;
    logic [IDX_W-1:0]  mem_idx;
    logic              mem_we;
    logic              wel;
    logic              stored;

    smt_sync #(
        .WIDTH    (3),
        .STAGES   (SYNC_STAGES),
        .RESET_VAL(3'b100)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({spi_cs_n, spi_sclk, spi_mosi}),
        .q    (pins_s)
    );

    smt_shifter u_shifter (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk_s     (pins_s[1]),
        .cs_n_s     (pins_s[2]),
        .mosi_s     (pins_s[0]),
        .tx_data    (tx_data),
        .frame_start(frame_start),
        .frame_end  (frame_end),
        .cs_active  (cs_active),
        .byte_valid (byte_valid),
        .rx_byte    (rx_byte),
        .miso_bit   (spi_miso)
    );

    smt_ctrl #(
        .IDX_W(IDX_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_start(frame_start),
        .frame_end  (frame_end),
        .byte_valid (byte_valid),
        .rx_byte    (rx_byte),
        .rd_data    (rd_data),
        .tx_data    (tx_data),
        .mem_we     (mem_we),
        .mem_idx    (mem_idx),
        .mem_wdata  (mem_wdata),
        .wel        (wel),
        .stored     (stored),
        .sleeping   (hibernating)
    );

    smt_store #(
        .DEPTH(DEPTH)
    ) u_store (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (mem_we),
        .idx  (mem_idx),
        .wdata(mem_wdata),
        .rdata(rd_data)
    );

endmodule

// File: rtl/smt_checker.sv
module smt_checker (
    input logic clk,
    input logic rst_n,
    input logic frame_start,
    input logic frame_end,
    input logic mem_we,
    input logic wel,
    input logic stored,
    input logic hibernating,
    input logic spi_miso
);

    assert_store_needs_latch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> wel);

    assert_latch_drops_after_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && stored) |=> !wel);

    assert_sleep_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (hibernating && !frame_start) |=> hibernating);

    assert_wake_on_select_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (hibernating && frame_start) |=> !hibernating);

    assert_sleep_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        hibernating |-> !spi_miso);

endmodule

bind serial_mem_target smt_checker u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_start(frame_start),
    .frame_end  (frame_end),
    .mem_we     (mem_we),
    .wel        (wel),
    .stored     (stored),
    .hibernating(hibernating),
    .spi_miso   (spi_miso)
);

// File: tb/serial_mem_target_bench.sv
module serial_mem_target_bench;

    localparam int HALF = 8;

    logic clk   = 1'b0;
    logic rst_n = 1'b0;
    logic sclk  = 1'b0;
    logic cs_n  = 1'b1;
    logic mosi  = 1'b0;
    logic miso;
    logic hib;

    int  total = 0;
    int  bad   = 0;
    bit  done  = 1'b0;

    always #10 clk = ~clk;

    serial_mem_target #(
        .DEPTH      (16),
        .SYNC_STAGES(2)
    ) u_serial_mem_target (
        .clk        (clk),
        .rst_n      (rst_n),
        .spi_sclk   (sclk),
        .spi_cs_n   (cs_n),
        .spi_mosi   (mosi),
        .spi_miso   (miso),
        .hibernating(hib)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic shift_bits(input logic [7:0] b, input int n, output logic [7:0] r);
        r = '0;
        for (int i = 7; i > 7 - n; i--) begin
            mosi = b[i];
            tick(HALF);
            r[i] = miso;
            sclk = 1'b1;
            tick(HALF);
            sclk = 1'b0;
        end
    endtask

    task automatic sel();
        cs_n = 1'b0;
        tick(HALF);
    endtask

    task automatic desel();
        tick(HALF);
        cs_n = 1'b1;
        tick(4 * HALF);
    endtask

    task automatic one_byte_cmd(input logic [7:0] op);
        logic [7:0] r;
        sel();
        shift_bits(op, 8, r);
        desel();
    endtask

    task automatic read_status(output logic [7:0] st);
        logic [7:0] r;
        sel();
        shift_bits(8'h05, 8, r);
        shift_bits(8'h00, 8, st);
        desel();
    endtask

    task automatic mem_write(input logic [7:0] a2, a1, a0, d);
        logic [7:0] r;
        sel();
        shift_bits(8'h02, 8, r);
        shift_bits(a2, 8, r);
        shift_bits(a1, 8, r);
        shift_bits(a0, 8, r);
        shift_bits(d, 8, r);
        desel();
    endtask

    task automatic mem_read(input logic [7:0] a2, a1, a0, output logic [7:0] d);
        logic [7:0] r;
        sel();
        shift_bits(8'h03, 8, r);
        check("R1", "MISO during read opcode", r, 8'h00);
        shift_bits(a2, 8, r);
        shift_bits(a1, 8, r);
        shift_bits(a0, 8, r);
        shift_bits(8'h00, 8, d);
        desel();
    endtask

    task automatic t_reset();
        check("R1", "MISO in reset", {7'b0, miso}, 8'h00);
        check("R1", "hibernate in reset", {7'b0, hib}, 8'h00);
        tick(4);
        rst_n = 1'b1;
        tick(4);
        check("R12", "MISO idle after reset", {7'b0, miso}, 8'h00);
    endtask

    task automatic t_latch();
        logic [7:0] st;
        read_status(st);
        check("R3", "status after reset", st, 8'h00);
        one_byte_cmd(8'h06);
        read_status(st);
        check("R2", "status after set-latch", st, 8'h02);
        one_byte_cmd(8'h04);
        read_status(st);
        check("R2", "status after clear-latch", st, 8'h00);
    endtask

    task automatic t_write_protect();
        logic [7:0] d;
        mem_write(8'h00, 8'h00, 8'h0A, 8'h5A);
        mem_read(8'h00, 8'h00, 8'h0A, d);
        check("R7", "write with latch clear", d, 8'h00);
    endtask

    task automatic t_write_read();
        logic [7:0] d;
        logic [7:0] st;
        one_byte_cmd(8'h06);
        mem_write(8'hF0, 8'h00, 8'h05, 8'hC4);
        read_status(st);
        check("R8", "latch after completed write", st, 8'h00);
        mem_read(8'h00, 8'h00, 8'h05, d);
        check("R4", "stored byte, MSB first (R5 R1)", d, 8'hC4);
        mem_read(8'hA0, 8'h00, 8'h05, d);
        check("R4", "upper nibble of first address byte ignored", d, 8'hC4);
        check("R12", "MISO after frame", {7'b0, miso}, 8'h00);
    endtask

    task automatic t_alias();
        logic [7:0] d;
        mem_read(8'h00, 8'h00, 8'h15, d);
        check("R6", "alias of 0x00015", d, 8'hC4);
        one_byte_cmd(8'h06);
        mem_write(8'h01, 8'h23, 8'h47, 8'h3C);
        mem_read(8'h00, 8'h00, 8'h07, d);
        check("R6", "write at 0x12347 seen at 0x00007", d, 8'h3C);
        mem_read(8'h00, 8'h00, 8'h05, d);
        check("R5", "neighbour untouched", d, 8'hC4);
    endtask

    task automatic t_abort();
        logic [7:0] r;
        logic [7:0] st;
        logic [7:0] d;
        one_byte_cmd(8'h06);
        sel();
        shift_bits(8'h02, 8, r);
        shift_bits(8'h00, 8, r);
        shift_bits(8'h00, 8, r);
        shift_bits(8'h09, 8, r);
        shift_bits(8'hAA, 4, r);
        desel();
        mem_read(8'h00, 8'h00, 8'h09, d);
        check("R9", "partial data byte not stored", d, 8'h00);
        read_status(st);
        check("R9", "latch kept after abandoned write", st, 8'h02);
        sel();
        shift_bits(8'h03, 3, r);
        desel();
        read_status(st);
        check("R9", "decode restarts after mid-opcode abort", st, 8'h02);
    endtask

    task automatic t_unknown();
        logic [7:0] ops [5] = '{8'h0B, 8'h42, 8'h9F, 8'hC2, 8'hBA};
        logic [7:0] r;
        logic [7:0] st;
        logic [7:0] d;
        foreach (ops[k]) begin
            sel();
            shift_bits(ops[k], 8, r);
            shift_bits(8'h00, 8, r);
            shift_bits(8'h00, 8, r);
            shift_bits(8'h05, 8, r);
            shift_bits(8'h77, 8, r);
            desel();
        end
        read_status(st);
        check("R10", "latch after unknown opcodes", st, 8'h02);
        mem_read(8'h00, 8'h00, 8'h05, d);
        check("R10", "memory after unknown opcodes", d, 8'hC4);
        one_byte_cmd(8'h04);
    endtask

    task automatic t_hibernate();
        logic [7:0] r;
        logic [7:0] st;
        logic [7:0] d;
        one_byte_cmd(8'hB9);
        check("R11", "hibernate after sleep frame", {7'b0, hib}, 8'h01);
        check("R12", "MISO while deselected in sleep", {7'b0, miso}, 8'h00);
        sel();
        check("R11", "wake on select", {7'b0, hib}, 8'h00);
        shift_bits(8'h06, 8, r);
        shift_bits(8'h00, 8, r);
        check("R11", "MISO in wake frame", r, 8'h00);
        desel();
        read_status(st);
        check("R11", "wake frame discarded", st, 8'h00);
        mem_read(8'h00, 8'h00, 8'h05, d);
        check("R11", "memory kept through sleep", d, 8'hC4);
    endtask

    initial begin
        t_reset();
        t_latch();
        t_write_protect();
        t_write_read();
        t_alias();
        t_abort();
        t_unknown();
        t_hibernate();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule